// File: doc/BRIEF.md
# Multichannel Audio Receive Holding Logic

This block sits behind the serial audio deserializers. Each deserializer delivers a finished sample word together with a channel number. The block keeps up to a fixed number of unread words per channel. It shows which channels hold data and which have lost data. Software reaches every channel through one shared read location, whose channel order depends on the configured mode.

In stereo mode, channel 0 is left and channel 1 is right. Reads alternate between them. In TDM mode, reads walk through the channels whose mask bit is set. Stereo mode also offers two packed formats, in which a single read returns a left and a right sample together. Samples are otherwise returned right-justified with zeros above them.

Top module: `rxh_top`

## Requirements
- R1: `rdy_o[i]` is 1 in the cycle after a word for channel i is accepted (`in_valid_i` with `in_ch_i`=i). It stays 1 while channel i holds an unread word and returns to 0 once its last word has been read.
- R2: Each channel stores `DEPTH` (default 2) unread words. A word that arrives for a full channel with no read of that channel in the same cycle sets `ovf_o[i]`. The oldest stored word is dropped, so the two newest are kept.
- R3: `ovf_o` bits stay set until a `stat_rd_i` pulse, which clears all of them. An overflow in the same cycle as `stat_rd_i` leaves its bit set.
- R4: With `mode_i`=0 (stereo) and `fmt_i`=0, successive successful reads return channel 0, then channel 1, then channel 0 again. The mask is ignored in this mode.
- R5: With `mode_i`=1 (TDM), successive successful reads step through the channels whose `ch_mask_i` bit is 1, in ascending order, and wrap from the highest to the lowest. `fmt_i` is ignored in this mode.
- R6: `rd_data_o` changes only in the cycle after `rd_stb_i` and holds its value otherwise. A read whose current channel holds no word returns 0 and leaves the channel pointer where it is.
- R7: In plain format (`fmt_i`=0 or 3, or any `fmt_i` in TDM mode), the sample occupies `rd_data_o[SW-1:0]` and the bits above it are 0.
- R8: With `fmt_i`=1 in stereo mode, a read returns `{ch1[15:0], ch0[15:0]}` and consumes one word from each of channels 0 and 1. If either of the two is empty, the read returns 0 and consumes nothing.
- R9: With `fmt_i`=2 in stereo mode, a read returns `{16'h0, ch1[7:0], ch0[7:0]}` and consumes one word from each of channels 0 and 1.
- R10: The channel pointer returns to the lowest enabled channel after reset and whenever `mode_i` or `fmt_i` changes.
- R11: After reset, `rd_data_o`, `rdy_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_i | input | 1 | 0 = stereo, 1 = TDM |
| fmt_i | input | 2 | 0 = plain, 1 = packed 16-bit, 2 = packed 8-bit, 3 = plain |
| ch_mask_i | input | NUM_CH | Enabled channels in TDM mode |
| in_valid_i | input | 1 | A completed sample word is presented |
| in_ch_i | input | $clog2(NUM_CH) | Channel number of the presented word |
| in_data_i | input | SW | Sample word |
| rd_stb_i | input | 1 | Read strobe for the shared data location |
| stat_rd_i | input | 1 | Status read strobe; clears the overflow flags |
| rd_data_o | output | 32 | Shared read data, registered |
| rdy_o | output | NUM_CH | Per-channel data-ready flags |
| ovf_o | output | NUM_CH | Per-channel sticky overflow flags |

## Verification
On every cycle the assertions check several properties at the ports: an accepted word raises its ready flag, overflow bits appear only alongside an incoming word and stay set until a status read, the read data holds between strobes, empty reads return zero, and the padding bits of plain and 8-bit packed reads are zero. Some behaviour needs planned sequences that only the bench scenarios provide. These are the channel order in each mode, the dropping of the oldest word on overflow, the restart of the pointer after a format change, and the packing of left and right samples.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  typedef enum logic {
    MODE_STEREO = 1'b0,
    MODE_TDM    = 1'b1
  } rxh_mode_e;

  typedef enum logic [1:0] {
    FMT_PLAIN  = 2'd0,
    FMT_PACK16 = 2'd1,
    FMT_PACK8  = 2'd2,
    FMT_RSVD   = 2'd3
  } rxh_fmt_e;

  localparam int unsigned OUT_W = 32;
endpackage

// File: rtl/rxh_chan_buf.sv
// Per-channel holding slots: circular store that overwrites the oldest
// word when a push meets a full store without a pop.
module rxh_chan_buf #(
  parameter int unsigned SW    = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [SW-1:0] data_i,
  input  logic          pop_i,
  output logic [SW-1:0] head_o,
  output logic          avail_o,
  output logic          ovf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [SW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wrp_q, wrp_n, rdp_q, rdp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pop_eff, full, drop_old;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    pop_eff  = pop_i && (cnt_q != '0);
    drop_old = push_i && full && !pop_eff;
    wrp_n    = push_i ? wrap_inc(wrp_q) : wrp_q;
    rdp_n    = (pop_eff || drop_old) ? wrap_inc(rdp_q) : rdp_q;
    cnt_n    = cnt_q + CW'(push_i) - CW'(pop_eff || drop_old);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrp_q <= '0;
      rdp_q <= '0;
      cnt_q <= '0;
    end else begin
      wrp_q <= wrp_n;
      rdp_q <= rdp_n;
      cnt_q <= cnt_n;
    end
  end

  // Data slots carry no reset; validity comes from cnt_q.
  always_ff @(posedge clk) begin
    if (push_i) slot_q[wrp_q] <= data_i;
  end

  assign head_o  = slot_q[rdp_q];
  assign avail_o = (cnt_q != '0);
  assign ovf_o   = drop_old;
endmodule

// File: rtl/rxh_seq.sv
// Channel sequence pointer over an enable mask.
module rxh_seq #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         en_i,
  input  logic                      advance_i,
  input  logic                      restart_i,
  output logic [$clog2(NUM_CH)-1:0] cur_o
);
  localparam int unsigned CHW = $clog2(NUM_CH);

  logic [CHW-1:0] ptr_q, ptr_n, first, cur, nxt;
  logic           found;

  always_comb begin
    first = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en_i[i]) first = CHW'(i);
    end
    cur = en_i[ptr_q] ? ptr_q : first;
    nxt   = cur;
    found = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      if (!found && en_i[(int'(cur) + k) % NUM_CH]) begin
        nxt   = CHW'((int'(cur) + k) % NUM_CH);
        found = 1'b1;
      end
    end
    if (restart_i)      ptr_n = first;
    else if (advance_i) ptr_n = nxt;
    else                ptr_n = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign cur_o = cur;
endmodule

// File: rtl/rxh_pack.sv
// Output word formatting: right-justified single sample or packed stereo pair.
module rxh_pack
  import rxh_pkg::*;
#(
  parameter int unsigned SW = 24
) (
  input  logic [1:0]       fmt_i,
  input  logic [SW-1:0]    sel_i,
  input  logic [15:0]      left_i,
  input  logic [15:0]      right_i,
  output logic [OUT_W-1:0] word_o
);
  always_comb begin
    unique case (rxh_fmt_e'(fmt_i))
      FMT_PACK16: word_o = {right_i, left_i};
      FMT_PACK8:  word_o = {16'h0000, right_i[7:0], left_i[7:0]};
      default:    word_o = OUT_W'(sel_i);
    endcase
  end
endmodule

// File: rtl/rxh_top.sv
module rxh_top
  import rxh_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SW     = 24,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_i,
  input  logic [1:0]                fmt_i,
  input  logic [NUM_CH-1:0]         ch_mask_i,
  input  logic                      in_valid_i,
  input  logic [$clog2(NUM_CH)-1:0] in_ch_i,
  input  logic [SW-1:0]             in_data_i,
  input  logic                      rd_stb_i,
  input  logic                      stat_rd_i,
  output logic [31:0]               rd_data_o,
  output logic [NUM_CH-1:0]         rdy_o,
  output logic [NUM_CH-1:0]         ovf_o
);
  localparam int unsigned CHW = $clog2(NUM_CH);

  logic [SW-1:0]     head_w [NUM_CH];
  logic [NUM_CH-1:0] push_v, pop_v, avail_v, ovf_evt_v;
  logic [NUM_CH-1:0] en_mask, ovf_q, ovf_n;
  logic [CHW-1:0]    cur_ch;
  logic [2:0]        cfg_q;
  logic              stereo, packed_rd, read_ok, take, restart;
  logic [1:0]        fmt_eff;
  logic [SW-1:0]     sel_word;
  logic [OUT_W-1:0]  pack_word, rd_data_q, rd_data_n;

  // Channel holding slots
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign push_v[g] = in_valid_i && (in_ch_i == CHW'(g));
    rxh_chan_buf #(.SW(SW), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_v[g]),
      .data_i  (in_data_i),
      .pop_i   (pop_v[g]),
      .head_o  (head_w[g]),
      .avail_o (avail_v[g]),
      .ovf_o   (ovf_evt_v[g])
    );
  end

  // Configuration decode and read control
  always_comb begin
    stereo    = (rxh_mode_e'(mode_i) == MODE_STEREO);
    en_mask   = stereo ? NUM_CH'(2'b11) : ch_mask_i;
    fmt_eff   = stereo ? fmt_i : 2'(FMT_PLAIN);
    packed_rd = (rxh_fmt_e'(fmt_eff) == FMT_PACK16) || (rxh_fmt_e'(fmt_eff) == FMT_PACK8);
    read_ok   = packed_rd ? (avail_v[0] && avail_v[1])
                          : (avail_v[cur_ch] && en_mask[cur_ch]);
    take      = rd_stb_i && read_ok;
    restart   = ({mode_i, fmt_i} != cfg_q);
    sel_word  = head_w[cur_ch];
    pop_v     = '0;
    if (take) begin
      if (packed_rd) pop_v[1:0]     = 2'b11;
      else           pop_v[cur_ch]  = 1'b1;
    end
    rd_data_n = take ? pack_word : '0;
    ovf_n     = (ovf_q & ~{NUM_CH{stat_rd_i}}) | ovf_evt_v;
  end

  rxh_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_mask),
    .advance_i (take && !packed_rd),
    .restart_i (restart),
    .cur_o     (cur_ch)
  );

  rxh_pack #(.SW(SW)) u_pack (
    .fmt_i   (fmt_eff),
    .sel_i   (sel_word),
    .left_i  (head_w[0][15:0]),
    .right_i (head_w[1][15:0]),
    .word_o  (pack_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      ovf_q     <= '0;
      cfg_q     <= '0;
    end else begin
      if (rd_stb_i) rd_data_q <= rd_data_n;
      ovf_q <= ovf_n;
      cfg_q <= {mode_i, fmt_i};
    end
  end

  assign rd_data_o = rd_data_q;
  assign rdy_o     = avail_v;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/rxh_check.sv
module rxh_check #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SW     = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mode_i,
  input logic [1:0]                fmt_i,
  input logic                      in_valid_i,
  input logic [$clog2(NUM_CH)-1:0] in_ch_i,
  input logic                      rd_stb_i,
  input logic                      stat_rd_i,
  input logic [31:0]               rd_data_o,
  input logic [NUM_CH-1:0]         rdy_o,
  input logic [NUM_CH-1:0]         ovf_o
);
  a_r1_rdy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (int'(in_ch_i) < NUM_CH)) |=> rdy_o[$past(in_ch_i)]);

  a_r2_ovf_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ((ovf_o & ~$past(ovf_o)) == '0));

  a_r3_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !in_valid_i) |=> (ovf_o == '0));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));

  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && (rdy_o == '0)) |=> (rd_data_o == '0));

  a_r9_pack8_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !mode_i && (fmt_i == 2'd2)) |=> (rd_data_o[31:16] == '0));

  if (SW < 32) begin : g_rjust
    a_r7_right_justified: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && (mode_i || fmt_i == 2'd0 || fmt_i == 2'd3)) |=> (rd_data_o[31:SW] == '0));
  end
endmodule

bind rxh_top rxh_check #(.NUM_CH(NUM_CH), .SW(SW)) u_rxh_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .fmt_i      (fmt_i),
  .in_valid_i (in_valid_i),
  .in_ch_i    (in_ch_i),
  .rd_stb_i   (rd_stb_i),
  .stat_rd_i  (stat_rd_i),
  .rd_data_o  (rd_data_o),
  .rdy_o      (rdy_o),
  .ovf_o      (ovf_o)
);

// File: tb/tb_rxh_top.sv
module tb_rxh_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SWD = 24;
  localparam int WD_CYCLES = 20000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           mode;
  logic [1:0]     fmt;
  logic [NCH-1:0] mask;
  logic           in_valid;
  logic [1:0]     in_ch;
  logic [SWD-1:0] in_data;
  logic           rd_stb, stat_rd;
  logic [31:0]    rd_data;
  logic [NCH-1:0] rdy, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxh_top #(.NUM_CH(NCH), .SW(SWD), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .fmt_i(fmt), .ch_mask_i(mask),
    .in_valid_i(in_valid), .in_ch_i(in_ch), .in_data_i(in_data),
    .rd_stb_i(rd_stb), .stat_rd_i(stat_rd),
    .rd_data_o(rd_data), .rdy_o(rdy), .ovf_o(ovf)
  );

  // Stimulus table: {op[1:0], ch[1:0], data[23:0], expected[31:0]}
  // op 0 = push word, op 1 = read and compare. Stereo, plain format.
  localparam int NTBL = 9;
  localparam logic [59:0] TBL [NTBL] = '{
    {2'd0, 2'd0, 24'h000111, 32'h0000_0000},
    {2'd0, 2'd1, 24'h000222, 32'h0000_0000},
    {2'd1, 2'd0, 24'h000000, 32'h0000_0111},
    {2'd1, 2'd0, 24'h000000, 32'h0000_0222},
    {2'd1, 2'd0, 24'h000000, 32'h0000_0000},
    {2'd0, 2'd1, 24'h000333, 32'h0000_0000},
    {2'd1, 2'd0, 24'h000000, 32'h0000_0000},
    {2'd0, 2'd0, 24'h000444, 32'h0000_0000},
    {2'd1, 2'd0, 24'h000000, 32'h0000_0444}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input logic [SWD-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'(ch); in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [31:0] exp);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic set_cfg(input logic m, input logic [1:0] f, input logic [NCH-1:0] k);
    @(negedge clk);
    mode = m; fmt = f; mask = k;
    @(negedge clk);
  endtask

  task automatic stat_pulse();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; fmt = 2'd0; mask = '0;
    in_valid = 1'b0; in_ch = '0; in_data = '0; rd_stb = 1'b0; stat_rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 rd_data", rd_data, 32'h0);
    check("R11 rdy", 32'(rdy), 32'h0);
    check("R11 ovf", 32'(ovf), 32'h0);

    // Table walk: R4 left/right order, R6 empty read keeps pointer
    for (int i = 0; i < NTBL; i++) begin
      if (TBL[i][59:58] == 2'd0) push(int'(TBL[i][57:56]), TBL[i][55:32]);
      else read_chk($sformatf("R4/R6 table row %0d", i), TBL[i][31:0]);
    end
    read_chk("R4 right after left", 32'h0000_0333);

    // R1 ready flag, R2 overflow keeps newest
    push(2, 24'h0000A0);
    check("R1 rdy set", 32'(rdy[2]), 32'h1);
    push(2, 24'h0000B0);
    check("R2 no ovf at two words", 32'(ovf[2]), 32'h0);
    push(2, 24'h0000C0);
    check("R2 ovf on third word", 32'(ovf[2]), 32'h1);
    stat_pulse();
    check("R3 ovf cleared by status read", 32'(ovf), 32'h0);

    // R5 TDM single channel, oldest dropped
    set_cfg(1'b1, 2'd0, 4'b0100);
    read_chk("R2 oldest dropped", 32'h0000_00B0);
    read_chk("R5 wrap to same channel", 32'h0000_00C0);
    check("R1 rdy cleared after last read", 32'(rdy[2]), 32'h0);
    read_chk("R6 empty read zero", 32'h0);

    // R5 TDM mask 1010
    set_cfg(1'b1, 2'd0, 4'b1010);
    push(3, 24'h000033);
    push(1, 24'h000011);
    push(3, 24'h000034);
    push(1, 24'h000012);
    read_chk("R5 first enabled", 32'h0000_0011);
    read_chk("R5 next enabled", 32'h0000_0033);
    read_chk("R5 wrap", 32'h0000_0012);
    read_chk("R5 last", 32'h0000_0034);

    // R3 overflow in same cycle as status read survives
    push(3, 24'h000001);
    push(3, 24'h000002);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'd3; in_data = 24'h000003; stat_rd = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; stat_rd = 1'b0;
    check("R3 new overflow wins over clear", 32'(ovf[3]), 32'h1);
    stat_pulse();
    check("R3 cleared", 32'(ovf[3]), 32'h0);

    // R10 pointer restart on format change
    set_cfg(1'b0, 2'd0, 4'b0000);
    push(0, 24'h000050);
    push(1, 24'h000051);
    read_chk("R4 left first", 32'h0000_0050);
    set_cfg(1'b0, 2'd2, 4'b0000);
    set_cfg(1'b0, 2'd0, 4'b0000);
    push(0, 24'h000052);
    read_chk("R10 restart to channel 0", 32'h0000_0052);
    read_chk("R4 right after restart", 32'h0000_0051);

    // R8 packed 16-bit
    set_cfg(1'b0, 2'd1, 4'b0000);
    push(0, 24'h00ABCD);
    read_chk("R8 one side empty returns zero", 32'h0);
    push(1, 24'h001234);
    read_chk("R8 packed 16", 32'h1234_ABCD);
    check("R8 both consumed", 32'(rdy[1:0]), 32'h0);

    // R9 packed 8-bit
    set_cfg(1'b0, 2'd2, 4'b0000);
    push(0, 24'h0000A5);
    push(1, 24'h00005A);
    read_chk("R9 packed 8", 32'h0000_5AA5);
    check("R9 both consumed", 32'(rdy[1:0]), 32'h0);

    // R7 right-justified full-width sample
    set_cfg(1'b0, 2'd0, 4'b0000);
    push(0, 24'hFFFFFF);
    read_chk("R7 right justified", 32'h00FF_FFFF);

    // R7 format ignored in TDM
    set_cfg(1'b1, 2'd1, 4'b0001);
    push(0, 24'h876543);
    read_chk("R7 TDM ignores packing", 32'h0087_6543);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule